// File: doc/BRIEF.md
# Posted Write Buffer with Read Stall

This block sits between a host request port and the memory write path. Host writes to memory space are posted into a small in-order queue and acknowledged at once, so the host sees low write latency. The queue drains towards memory one entry per memory acknowledge. A host read is held off (stalled) until every write queued before it has been accepted by memory. This keeps the data coherent, and it gives the host a way to confirm that a batch of writes has landed: it issues a read and waits for it to complete.

Writes to the block's own control register use a separate register-access port and never enter the queue, so a new setting is in force on the very next cycle, whatever is still queued. Broadcast writes carry no acknowledge handshake and cannot be held off. When one arrives while the queue is full it is discarded, and a sticky overflow flag records the loss. Any register write clears that flag.

Top module: `wrpost_buffer`

## Requirements
- R1: A non-broadcast write (host_req=1, host_we=1, host_bcast=0) that arrives while the queue holds fewer than DEPTH entries is acknowledged with host_ack=1 in that same cycle. It is presented on the memory write port from the next cycle.
- R2: Queued writes leave in arrival order, one per cycle in which mem_wvalid and mem_wack are both 1. mem_wvalid is 1 exactly while the queue holds an entry, and mem_waddr/mem_wdata hold steady until the acknowledge arrives.
- R3: While the queue holds DEPTH entries at the start of a cycle, a non-broadcast write gets host_ack=0 and is not queued, even if an entry drains in that cycle. It is acknowledged in the first cycle that begins with free space.
- R4: A broadcast write (host_req=1, host_we=1, host_bcast=1) never gets host_ack. It is queued if the queue has space. If the queue is full it is discarded, never reaches memory, and ovf_flag reads 1 from the next cycle.
- R5: ovf_flag stays at 1 until a register write (reg_wr=1). From the cycle after that write it reads 0.
- R6: A register write loads reg_wdata into ctrl_value, visible the cycle after reg_wr. This happens whatever the queue holds, and nothing is added to the queue.
- R7: A read (host_req=1, host_we=0; host_bcast is ignored) sees host_stall=1 and host_ack=0 while any queued write has not been acknowledged by memory. It completes with host_ack=1 and host_stall=0 in the first cycle the queue is empty.
- R8: After reset the queue is empty (mem_wvalid=0), ovf_flag=0, host_stall=0, and ctrl_value equals the CTRL_RST parameter.
- R9: A read that arrives while the queue is empty completes in that same cycle, with host_stall never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Host request present; held until acknowledged, except broadcasts (one cycle) |
| host_we | input | 1 | 1 = write, 0 = read |
| host_bcast | input | 1 | Write is a broadcast with no acknowledge handshake |
| host_addr | input | AW | Write address |
| host_wdata | input | DW | Write data |
| host_ack | output | 1 | Request completes this cycle |
| host_stall | output | 1 | Read held off while queued writes drain |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | CW | Control register write value |
| ctrl_value | output | CW | Current control register contents |
| ovf_flag | output | 1 | Sticky broadcast overflow flag |
| mem_wvalid | output | 1 | Queue head presented to memory |
| mem_waddr | output | AW | Address of queue head |
| mem_wdata | output | DW | Data of queue head |
| mem_wack | input | 1 | Memory accepts the presented write |

## Verification
Some rules are checked by the embedded properties on every cycle. The queue never accepts an entry while full and never releases one while empty. The memory-side address and data hold until acknowledged, and a completed read never coincides with a pending memory write. A broadcast is never acknowledged and a dropped broadcast always raises the flag. Register writes land one cycle later, and the flag persists until a register write. Other behaviour can only be shown by the bench's scenarios: the order in which entries reach memory, the absence of dropped broadcasts and register writes from that stream, and the exact cycle in which a full queue frees up and a stalled read completes.

// File: rtl/wrpost_pkg.sv
package wrpost_pkg;

   typedef enum logic [1:0] {
      REQ_IDLE  = 2'd0,
      REQ_WRITE = 2'd1,
      REQ_BCAST = 2'd2,
      REQ_READ  = 2'd3
   } req_kind_e;

   // Sort a host request into its kind; the broadcast bit only matters on writes.
   function automatic req_kind_e classify_req(input logic req, input logic we, input logic bc);
      if (!req)     return REQ_IDLE;
      else if (!we) return REQ_READ;
      else if (bc)  return REQ_BCAST;
      else          return REQ_WRITE;
   endfunction

endpackage

// File: rtl/wrpost_fifo.sv
module wrpost_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int PW   = $clog2(DEPTH);
   localparam int CNTW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("wrpost_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("wrpost_fifo: W must be positive");
   end

   logic [W-1:0]    slot_q [DEPTH];
   logic [PW-1:0]   wr_q, rd_q, wr_nx, rd_nx;
   logic [CNTW-1:0] cnt_q;

   if ((1 << PW) == DEPTH) begin : g_pow2
      assign wr_nx = wr_q + PW'(1);
      assign rd_nx = rd_q + PW'(1);
   end else begin : g_wrap
      assign wr_nx = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
      assign rd_nx = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= wr_nx;
         if (pop)  rd_q <= rd_nx;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + CNTW'(1);
            2'b01:   cnt_q <= cnt_q - CNTW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) slot_q[wr_q] <= din;
   end

   assign dout  = slot_q[rd_q];
   assign full  = (cnt_q == CNTW'(DEPTH));
   assign empty = (cnt_q == '0);

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full)
      else $error("queue pushed while full");
   // R2
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty)
      else $error("queue popped while empty");

endmodule

// File: rtl/wrpost_ctrl_reg.sv
module wrpost_ctrl_reg #(
   parameter int          CW   = 8,
   parameter logic [CW-1:0] RSTV = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [CW-1:0] wdata,
   input  logic          ovf_set,
   output logic [CW-1:0] ctrl_q,
   output logic          ovf_q
);
   if (CW < 1) begin : g_bad_cw
      $error("wrpost_ctrl_reg: CW must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= RSTV;
         ovf_q  <= 1'b0;
      end else begin
         if (wr_en) ctrl_q <= wdata;
         // A new loss in the same cycle as a clear is kept.
         if (ovf_set)    ovf_q <= 1'b1;
         else if (wr_en) ovf_q <= 1'b0;
      end
   end

   // R6
   ctrl_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ctrl_q == $past(wdata)))
      else $error("register write not applied next cycle");
   // R5
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !wr_en) |=> ovf_q)
      else $error("overflow flag lost without a register write");

endmodule

// File: rtl/wrpost_buffer.sv
module wrpost_buffer #(
   parameter int            AW       = 16,
   parameter int            DW       = 32,
   parameter int            DEPTH    = 4,
   parameter int            CW       = 8,
   parameter logic [CW-1:0] CTRL_RST = 8'h5A
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_req,
   input  logic          host_we,
   input  logic          host_bcast,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] host_wdata,
   output logic          host_ack,
   output logic          host_stall,
   input  logic          reg_wr,
   input  logic [CW-1:0] reg_wdata,
   output logic [CW-1:0] ctrl_value,
   output logic          ovf_flag,
   output logic          mem_wvalid,
   output logic [AW-1:0] mem_waddr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_wack
);
   import wrpost_pkg::*;

   localparam int EW = AW + DW;

   if (AW < 1 || DW < 1) begin : g_bad_bus
      $error("wrpost_buffer: AW and DW must be positive");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("wrpost_buffer: DEPTH must be at least 2");
   end

   req_kind_e     kind;
   logic          q_full, q_empty;
   logic          wr_take, bc_take, bc_drop, rd_done;
   logic          q_push, q_pop;
   logic [EW-1:0] q_head;

   assign kind    = classify_req(host_req, host_we, host_bcast);
   assign wr_take = (kind == REQ_WRITE) && !q_full;
   assign bc_take = (kind == REQ_BCAST) && !q_full;
   assign bc_drop = (kind == REQ_BCAST) &&  q_full;
   assign rd_done = (kind == REQ_READ)  &&  q_empty;

   assign q_push     = wr_take || bc_take;
   assign q_pop      = mem_wvalid && mem_wack;
   assign host_ack   = wr_take || rd_done;
   assign host_stall = (kind == REQ_READ) && !q_empty;

   wrpost_fifo #(.DEPTH(DEPTH), .W(EW)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push),
      .din   ({host_addr, host_wdata}),
      .pop   (q_pop),
      .dout  (q_head),
      .full  (q_full),
      .empty (q_empty)
   );

   assign mem_wvalid = !q_empty;
   assign mem_waddr  = q_head[DW +: AW];
   assign mem_wdata  = q_head[DW-1:0];

   wrpost_ctrl_reg #(.CW(CW), .RSTV(CTRL_RST)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .wdata   (reg_wdata),
      .ovf_set (bc_drop),
      .ctrl_q  (ctrl_value),
      .ovf_q   (ovf_flag)
   );

   // R1
   post_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_ack && host_we) |=> mem_wvalid)
      else $error("acknowledged write not presented to memory");
   // R2
   head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wvalid && !mem_wack) |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)))
      else $error("memory write changed before acknowledge");
   // R4
   bcast_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && host_we && host_bcast) |-> !host_ack)
      else $error("broadcast write acknowledged");
   // R4
   drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bc_drop |=> ovf_flag)
      else $error("dropped broadcast did not raise flag");
   // R7
   read_coherent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_ack && !host_we) |-> !mem_wvalid)
      else $error("read completed with writes outstanding");
   // R7
   stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_stall && host_ack))
      else $error("stall and acknowledge together");

endmodule

// File: tb/wrpost_buffer_test.sv
module wrpost_buffer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0, host_we = 1'b0, host_bcast = 1'b0;
   logic [15:0] host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic        host_ack, host_stall;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  ctrl_value;
   logic        ovf_flag, mem_wvalid;
   logic [15:0] mem_waddr;
   logic [31:0] mem_wdata;
   logic        mem_wack = 1'b0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   wrpost_buffer #(.AW(16), .DW(32), .DEPTH(4), .CW(8), .CTRL_RST(8'h5A)) uut (
      .clk(clk), .rst_n(rst_n),
      .host_req(host_req), .host_we(host_we), .host_bcast(host_bcast),
      .host_addr(host_addr), .host_wdata(host_wdata),
      .host_ack(host_ack), .host_stall(host_stall),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .ctrl_value(ctrl_value), .ovf_flag(ovf_flag),
      .mem_wvalid(mem_wvalid), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .mem_wack(mem_wack)
   );

   typedef struct packed {
      logic        req, we, bc;
      logic [15:0] addr;
      logic        wack, eack, estall, evalid;
      logic [15:0] eaddr;
   } vec_t;

   // One row per cycle; data is always {16'hBEEF, addr}.
   localparam vec_t VECS [11] = '{
      '{1'b1,1'b1,1'b0,16'h0010, 1'b0, 1'b1,1'b0,1'b0,16'h0000},
      '{1'b1,1'b1,1'b0,16'h0011, 1'b0, 1'b1,1'b0,1'b1,16'h0010},
      '{1'b1,1'b0,1'b0,16'h0000, 1'b1, 1'b0,1'b1,1'b1,16'h0010},
      '{1'b1,1'b0,1'b0,16'h0000, 1'b0, 1'b0,1'b1,1'b1,16'h0011},
      '{1'b1,1'b0,1'b0,16'h0000, 1'b1, 1'b0,1'b1,1'b1,16'h0011},
      '{1'b1,1'b0,1'b0,16'h0000, 1'b0, 1'b1,1'b0,1'b0,16'h0000},
      '{1'b0,1'b0,1'b0,16'h0000, 1'b0, 1'b0,1'b0,1'b0,16'h0000},
      '{1'b1,1'b1,1'b1,16'h0020, 1'b0, 1'b0,1'b0,1'b0,16'h0000},
      '{1'b1,1'b1,1'b0,16'h0021, 1'b1, 1'b1,1'b0,1'b1,16'h0020},
      '{1'b0,1'b0,1'b0,16'h0000, 1'b1, 1'b0,1'b0,1'b1,16'h0021},
      '{1'b1,1'b0,1'b1,16'h0000, 1'b0, 1'b1,1'b0,1'b0,16'h0000}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic r, input logic w, input logic b, input logic [15:0] a, input logic k);
      @(negedge clk);
      host_req = r; host_we = w; host_bcast = b;
      host_addr = a; host_wdata = {16'hBEEF, a};
      mem_wack = k; reg_wr = 1'b0;
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int pops;
      logic [15:0] exp_order [4];
      exp_order = '{16'h0032, 16'h0033, 16'h0034, 16'h0035};

      repeat (3) @(posedge clk);
      #1;
      // R8 reset state
      chk("R8 mem_wvalid", mem_wvalid, 0);
      chk("R8 ovf_flag", ovf_flag, 0);
      chk("R8 ctrl_value", ctrl_value, 8'h5A);
      chk("R8 host_stall", host_stall, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // Table walk: R1 R2 R4 R7 R9
      for (int i = 0; i < 11; i++) begin
         drive(VECS[i].req, VECS[i].we, VECS[i].bc, VECS[i].addr, VECS[i].wack);
         chk("R1/R7 host_ack", host_ack, VECS[i].eack);
         chk("R7/R9 host_stall", host_stall, VECS[i].estall);
         chk("R2 mem_wvalid", mem_wvalid, VECS[i].evalid);
         if (VECS[i].evalid) begin
            chk("R2 mem_waddr", mem_waddr, VECS[i].eaddr);
            chk("R2 mem_wdata", mem_wdata, {16'hBEEF, VECS[i].eaddr});
         end
      end

      // R1 fill the queue without memory acknowledge
      for (int i = 0; i < 4; i++) begin
         drive(1, 1, 0, 16'h0031 + 16'(i), 0);
         chk("R1 fill ack", host_ack, 1);
      end
      // R3 full: fifth write held off
      drive(1, 1, 0, 16'h0035, 0);
      chk("R3 full no ack", host_ack, 0);
      drive(1, 1, 0, 16'h0035, 1);
      chk("R3 full with drain no ack", host_ack, 0);
      drive(1, 1, 0, 16'h0035, 0);
      chk("R3 ack after space", host_ack, 1);

      // R6 register write while queue is full
      drive(0, 0, 0, 16'h0000, 0);
      reg_wr = 1'b1; reg_wdata = 8'hC3;
      drive(0, 0, 0, 16'h0000, 0);
      chk("R6 ctrl next cycle", ctrl_value, 8'hC3);
      chk("R6 head unchanged", mem_waddr, 16'h0032);

      // R4 broadcast into full queue is dropped
      drive(1, 1, 1, 16'h0077, 0);
      chk("R4 bcast no ack", host_ack, 0);
      drive(0, 0, 0, 16'h0000, 0);
      chk("R4 ovf set", ovf_flag, 1);
      drive(0, 0, 0, 16'h0000, 0);
      drive(0, 0, 0, 16'h0000, 0);
      chk("R5 ovf sticky", ovf_flag, 1);
      reg_wr = 1'b1; reg_wdata = 8'h3C;
      drive(0, 0, 0, 16'h0000, 0);
      chk("R5 ovf cleared", ovf_flag, 0);
      chk("R6 ctrl second write", ctrl_value, 8'h3C);

      // R7 read drains queue; R2 order; R4/R6 nothing extra queued
      pops = 0;
      for (int i = 0; i < 8; i++) begin
         drive(1, 0, 0, 16'h0000, 1);
         if (mem_wvalid) begin
            chk("R7 stall while pending", host_stall, 1);
            chk("R7 no ack while pending", host_ack, 0);
            if (pops < 4) chk("R2 drain order", mem_waddr, exp_order[pops]);
            pops++;
         end else begin
            chk("R7 ack on empty", host_ack, 1);
            chk("R7 stall low on empty", host_stall, 0);
            break;
         end
      end
      chk("R4/R6 drained entry count", pops, 4);
      drive(0, 0, 0, 16'h0000, 0);
      finish_run();
   end

endmodule